// File: doc/BRIEF.md
# Flash Block Protection Controller

This block holds the protection state of every erase block in a banked flash array and decides, at the start of each program or erase, whether that operation may go ahead. Software-level lock, unlock and pin commands arrive with a block index. A write-protect pin decides whether pinned blocks may be released. A single digital flag reports whether the programming supply is above its lockout level.

A program or erase request is answered one cycle after its start strobe with either a grant or a reject. A reject carries a flag for each cause. A granted operation holds a busy indication until the array reports completion. While busy, the supply flag and any lock changes are no longer consulted for that operation. The state of any block can be read back through a registered status port. A small configuration register sits beside the lock bank and returns to its default value on every hardware reset.

Top module: `flash_blk_guard`

## Requirements
- R1: While `rst_n` is low, and after its release, every block reads as locked (2'b01), `cfg_q` equals `CFG_RESET`, and `pe_busy`, `pe_grant` and `pe_reject` are 0.
- R2: A command with `cmd_op` 2'b00 sets the addressed block to unlocked (2'b00), and 2'b01 sets it to locked (2'b01). The pinned case of R4 is the exception. `cmd_op` 2'b11 has no effect, and blocks other than `cmd_blk` never change. A block state is always one of 2'b00, 2'b01 or 2'b11.
- R3: A command with `cmd_op` 2'b10 sets the addressed block to pinned (2'b11) whatever the level of `wp_n`.
- R4: While `wp_n` is 0, lock and unlock commands leave a pinned block at 2'b11.
- R5: While `wp_n` is 1, a pinned block follows lock and unlock commands like any other block.
- R6: A command presented in cycle N governs a request started in cycle N+1.
- R7: A start on a block whose state is not 2'b00 gives `pe_reject` and `pe_err_lock` one cycle later, and the block state does not change. A start on an unlocked block with `vpp_ok` high gives `pe_grant` one cycle later. Grant and reject never occur together.
- R8: A start with `vpp_ok` low gives `pe_reject` and `pe_err_vpp` one cycle later, whatever the block state.
- R9: A grant raises `pe_busy` together with `pe_grant`. `pe_busy` then stays high until a cycle with `pe_done`, however `vpp_ok` or the lock states change. A start while busy produces no grant and no reject.
- R10: `rd_state` presents, one cycle after `rd_blk` is applied, the 2-bit state of that block.
- R11: `cfg_wr` loads `cfg_wdata` into `cfg_q` at the next edge. A hardware reset restores `CFG_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asserted asynchronously |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | 00 unlock, 01 lock, 10 pin, 11 no operation |
| cmd_blk | input | IDX_W | Block addressed by the command |
| wp_n | input | 1 | Write-protect pin; low keeps pinned blocks fixed |
| pe_start | input | 1 | Program or erase start strobe |
| pe_blk | input | IDX_W | Block targeted by the start |
| vpp_ok | input | 1 | Programming supply above lockout level |
| pe_done | input | 1 | Running operation has completed |
| rd_blk | input | IDX_W | Block whose state is read |
| rd_state | output | 2 | State of `rd_blk`, one cycle later |
| pe_grant | output | 1 | One-cycle grant pulse |
| pe_reject | output | 1 | One-cycle reject pulse |
| pe_err_lock | output | 1 | Reject cause: block not unlocked |
| pe_err_vpp | output | 1 | Reject cause: supply below lockout |
| pe_busy | output | 1 | A granted operation is running |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_q | output | CFG_W | Configuration register value |

## Verification
Each result is due at a fixed edge. Grant, reject, both error flags and the rise of busy appear at the first rising edge after the start strobe. A lock command takes effect at the first edge, so a start in the next cycle already sees the new state. The status read and the configuration register also appear one edge after their inputs. The bench drives every input just after a falling edge and samples 1 ns after the following rising edge, so each comparison lands on the cycle where the value is due. It keeps its own model of every block state and of the busy flag, and computes the expected answer from that model before the edge.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    BLK_OPEN   = 2'b00,
    BLK_LOCKED = 2'b01,
    BLK_PINNED = 2'b11
  } blk_state_e;

  typedef enum logic [1:0] {
    OP_UNLOCK = 2'b00,
    OP_LOCK   = 2'b01,
    OP_PIN    = 2'b10,
    OP_NONE   = 2'b11
  } lock_op_e;
endpackage

// File: rtl/fbp_rst_sync.sv
module fbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/fbp_lock_bank.sv
module fbp_lock_bank
  import fbp_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int FLAT_W = 2 * NUM_BLOCKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_blk,
  input  logic              wp_n,
  input  logic [IDX_W-1:0]  rd_blk,
  output logic [FLAT_W-1:0] state_flat,
  output logic [1:0]        rd_state
);
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic [1:0] st_q;
    logic [1:0] st_d;
    logic       hit;
    logic       frozen;

    assign hit    = cmd_valid && (cmd_blk == IDX_W'(g));
    assign frozen = (st_q == BLK_PINNED) && !wp_n;

    always_comb begin
      st_d = st_q;
      unique case (cmd_op)
        OP_UNLOCK: if (!frozen) st_d = BLK_OPEN;
        OP_LOCK:   if (!frozen) st_d = BLK_LOCKED;
        OP_PIN:    st_d = BLK_PINNED;
        default:   st_d = st_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= BLK_LOCKED;
      else if (hit) st_q <= st_d;
    end

    assign state_flat[2*g +: 2] = st_q;
  end

  logic [1:0] rd_d;
  assign rd_d = state_flat[{rd_blk, 1'b0} +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_state <= BLK_LOCKED;
    else        rd_state <= rd_d;
  end
endmodule

// File: rtl/fbp_pe_gate.sv
module fbp_pe_gate
  import fbp_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int FLAT_W = 2 * NUM_BLOCKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_start,
  input  logic [IDX_W-1:0]  pe_blk,
  input  logic              vpp_ok,
  input  logic              pe_done,
  input  logic [FLAT_W-1:0] state_flat,
  output logic              pe_grant,
  output logic              pe_reject,
  output logic              pe_err_lock,
  output logic              pe_err_vpp,
  output logic              pe_busy
);
  logic [1:0] sel_state;
  logic       accept;
  logic       grant_d, reject_d, elock_d, evpp_d, busy_d;

  assign sel_state = state_flat[{pe_blk, 1'b0} +: 2];
  assign accept    = pe_start && !pe_busy;

  always_comb begin
    elock_d  = accept && (sel_state != BLK_OPEN);
    evpp_d   = accept && !vpp_ok;
    grant_d  = accept && !elock_d && !evpp_d;
    reject_d = elock_d || evpp_d;
    busy_d   = pe_busy ? !pe_done : grant_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_grant    <= 1'b0;
      pe_reject   <= 1'b0;
      pe_err_lock <= 1'b0;
      pe_err_vpp  <= 1'b0;
      pe_busy     <= 1'b0;
    end else begin
      pe_grant    <= grant_d;
      pe_reject   <= reject_d;
      pe_err_lock <= elock_d;
      pe_err_vpp  <= evpp_d;
      pe_busy     <= busy_d;
    end
  end
endmodule

// File: rtl/flash_blk_guard.sv
module flash_blk_guard #(
  parameter int NUM_BLOCKS = 8,
  parameter int CFG_W      = 16,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h8C05,
  localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             wp_n,
  input  logic             pe_start,
  input  logic [IDX_W-1:0] pe_blk,
  input  logic             vpp_ok,
  input  logic             pe_done,
  input  logic [IDX_W-1:0] rd_blk,
  output logic [1:0]       rd_state,
  output logic             pe_grant,
  output logic             pe_reject,
  output logic             pe_err_lock,
  output logic             pe_err_vpp,
  output logic             pe_busy,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int FLAT_W = 2 * NUM_BLOCKS;

  logic              rst_core_n;
  logic [FLAT_W-1:0] blk_state_flat;
  logic [CFG_W-1:0]  cfg_d;

  fbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  fbp_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_blk    (cmd_blk),
    .wp_n       (wp_n),
    .rd_blk     (rd_blk),
    .state_flat (blk_state_flat),
    .rd_state   (rd_state)
  );

  fbp_pe_gate #(.NUM_BLOCKS(NUM_BLOCKS)) u_gate (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pe_start    (pe_start),
    .pe_blk      (pe_blk),
    .vpp_ok      (vpp_ok),
    .pe_done     (pe_done),
    .state_flat  (blk_state_flat),
    .pe_grant    (pe_grant),
    .pe_reject   (pe_reject),
    .pe_err_lock (pe_err_lock),
    .pe_err_vpp  (pe_err_vpp),
    .pe_busy     (pe_busy)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cfg_q <= CFG_RESET;
    else             cfg_q <= cfg_d;
  end
endmodule

// File: rtl/flash_blk_guard_chk.sv
module flash_blk_guard_chk #(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int FLAT_W = 2 * NUM_BLOCKS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [IDX_W-1:0]  cmd_blk,
  input logic              wp_n,
  input logic              pe_start,
  input logic [IDX_W-1:0]  pe_blk,
  input logic              vpp_ok,
  input logic              pe_done,
  input logic              pe_grant,
  input logic              pe_reject,
  input logic              pe_err_lock,
  input logic              pe_err_vpp,
  input logic              pe_busy,
  input logic [FLAT_W-1:0] state_flat
);
  function automatic logic [1:0] st(input logic [FLAT_W-1:0] f, input logic [IDX_W-1:0] i);
    return f[{i, 1'b0} +: 2];
  endfunction

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe_grant && pe_reject));

  p_grant_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_start && !pe_busy) |=>
      (pe_grant == ($past(vpp_ok) && (st($past(state_flat), $past(pe_blk)) == 2'b00))));

  p_lock_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_start && !pe_busy && (st(state_flat, pe_blk) != 2'b00)) |=> (pe_reject && pe_err_lock));

  p_vpp_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_start && !pe_busy && !vpp_ok) |=> (pe_reject && pe_err_vpp));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_busy && !pe_done) |=> pe_busy);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pe_busy |=> (!pe_grant && !pe_reject));

  p_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'b10)) |=> (st(state_flat, $past(cmd_blk)) == 2'b11));

  p_pin_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wp_n && (st(state_flat, cmd_blk) == 2'b11)) |=>
      (st(state_flat, $past(cmd_blk)) == 2'b11));
endmodule

bind flash_blk_guard flash_blk_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_blk     (cmd_blk),
  .wp_n        (wp_n),
  .pe_start    (pe_start),
  .pe_blk      (pe_blk),
  .vpp_ok      (vpp_ok),
  .pe_done     (pe_done),
  .pe_grant    (pe_grant),
  .pe_reject   (pe_reject),
  .pe_err_lock (pe_err_lock),
  .pe_err_vpp  (pe_err_vpp),
  .pe_busy     (pe_busy),
  .state_flat  (blk_state_flat)
);

// File: tb/test_flash_blk_guard.sv
`timescale 1ns/1ps
module test_flash_blk_guard;
  localparam int NB = 8;
  localparam int IW = 3;
  localparam int CW = 16;
  localparam logic [CW-1:0] CFG_DEF = 16'h8C05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [IW-1:0] cmd_blk = '0;
  logic wp_n = 1'b1;
  logic pe_start = 1'b0;
  logic [IW-1:0] pe_blk = '0;
  logic vpp_ok = 1'b1;
  logic pe_done = 1'b0;
  logic [IW-1:0] rd_blk = '0;
  logic [1:0] rd_state;
  logic pe_grant, pe_reject, pe_err_lock, pe_err_vpp, pe_busy;
  logic cfg_wr = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [1:0] m_st [NB];
  bit m_busy;
  logic [CW-1:0] m_cfg;

  always #2 clk = ~clk;

  flash_blk_guard #(.NUM_BLOCKS(NB), .CFG_W(CW), .CFG_RESET(CFG_DEF)) i_flash_blk_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .wp_n(wp_n), .pe_start(pe_start), .pe_blk(pe_blk), .vpp_ok(vpp_ok), .pe_done(pe_done),
    .rd_blk(rd_blk), .rd_state(rd_state), .pe_grant(pe_grant), .pe_reject(pe_reject),
    .pe_err_lock(pe_err_lock), .pe_err_vpp(pe_err_vpp), .pe_busy(pe_busy),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q));

  function automatic logic [1:0] next_state(logic [1:0] cur, logic [1:0] op, logic wp);
    if (op == 2'b10) return 2'b11;
    if (op == 2'b11) return cur;
    if (cur == 2'b11 && !wp) return cur;
    return (op == 2'b00) ? 2'b00 : 2'b01;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) m_st[i] = 2'b01;
    m_busy = 0;
    m_cfg = CFG_DEF;
  endtask

  task automatic do_cmd(logic [1:0] op, logic [IW-1:0] b, logic wp);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_blk = b; wp_n = wp;
    @(posedge clk);
    m_st[b] = next_state(m_st[b], op, wp);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_read(logic [IW-1:0] b, string req);
    @(negedge clk);
    rd_blk = b;
    @(posedge clk); #1;
    chk(req, 32'(rd_state), 32'(m_st[b]));
  endtask

  task automatic do_req(logic [IW-1:0] b, logic v, string req);
    bit eg, elk, evp;
    @(negedge clk);
    pe_start = 1; pe_blk = b; vpp_ok = v;
    elk = !m_busy && (m_st[b] != 2'b00);
    evp = !m_busy && !v;
    eg  = !m_busy && !elk && !evp;
    @(posedge clk); #1;
    chk({req, " grant"},  32'(pe_grant), 32'(eg));
    chk({req, " reject"}, 32'(pe_reject), 32'(elk || evp));
    chk({req, " err_lock"}, 32'(pe_err_lock), 32'(elk));
    chk({req, " err_vpp"},  32'(pe_err_vpp), 32'(evp));
    if (eg) m_busy = 1;
    chk({req, " busy"}, 32'(pe_busy), 32'(m_busy));
    @(negedge clk);
    pe_start = 0;
  endtask

  task automatic do_done();
    @(negedge clk);
    pe_done = 1;
    @(posedge clk); #1;
    m_busy = 0;
    chk("R9 busy clears on done", 32'(pe_busy), 0);
    @(negedge clk);
    pe_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    chk("R1 busy during reset", 32'(pe_busy), 0);
    chk("R1 cfg during reset", 32'(cfg_q), 32'(CFG_DEF));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R1: reset state
    chk("R1 grant", 32'(pe_grant), 0);
    chk("R1 reject", 32'(pe_reject), 0);
    chk("R1 cfg", 32'(cfg_q), 32'(CFG_DEF));
    for (int i = 0; i < NB; i++) do_read(IW'(i), "R1 block locked after reset");

    // R7: locked block rejected, state unchanged
    do_req(3'd2, 1'b1, "R7 locked block");
    do_read(3'd2, "R7 state unchanged after reject");

    // R6: unlock in cycle N, request in N+1
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00; cmd_blk = 3'd3; wp_n = 1;
    @(posedge clk);
    m_st[3] = 2'b00;
    @(negedge clk);
    cmd_valid = 0; pe_start = 1; pe_blk = 3'd3; vpp_ok = 1;
    @(posedge clk); #1;
    chk("R6 grant next cycle", 32'(pe_grant), 1);
    chk("R6 busy", 32'(pe_busy), 1);
    m_busy = 1;
    @(negedge clk);
    pe_start = 0;

    // R9: busy held through vpp drop and lock change, start ignored
    @(negedge clk); vpp_ok = 0;
    do_cmd(2'b01, 3'd3, 1'b1);
    @(posedge clk); #1;
    chk("R9 busy holds", 32'(pe_busy), 1);
    do_req(3'd1, 1'b1, "R9 start while busy");
    do_done();
    do_req(3'd1, 1'b1, "R9 after done");

    // R8: vpp low on an unlocked block
    do_cmd(2'b00, 3'd5, 1'b1);
    do_req(3'd5, 1'b0, "R8 vpp low");
    do_req(3'd5, 1'b1, "R7 unlocked grant");
    do_done();

    // R3/R4/R5: pin and write-protect
    do_cmd(2'b10, 3'd6, 1'b0);
    do_read(3'd6, "R3 pinned with wp low");
    do_cmd(2'b00, 3'd6, 1'b0);
    do_read(3'd6, "R4 unlock ignored with wp low");
    do_cmd(2'b01, 3'd6, 1'b0);
    do_read(3'd6, "R4 lock ignored with wp low");
    do_cmd(2'b00, 3'd6, 1'b1);
    do_read(3'd6, "R5 unlock with wp high");
    do_cmd(2'b10, 3'd6, 1'b1);
    do_cmd(2'b01, 3'd6, 1'b1);
    do_read(3'd6, "R5 lock with wp high");
    do_cmd(2'b11, 3'd5, 1'b1);
    do_read(3'd5, "R2 no-op code");
    do_read(3'd4, "R2 neighbour untouched");

    // R11: config register
    @(negedge clk); cfg_wr = 1; cfg_wdata = 16'h3A71;
    @(posedge clk); #1;
    m_cfg = 16'h3A71;
    chk("R11 cfg write", 32'(cfg_q), 32'(m_cfg));
    @(negedge clk); cfg_wr = 0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int act;
      act = int'($urandom % 6);
      case (act)
        0, 1: do_cmd(2'($urandom), IW'($urandom), 1'($urandom));
        2: do_read(IW'($urandom), "R10 random read");
        3, 4: do_req(IW'($urandom), ($urandom % 4) != 0, "R7 random request");
        default: if (m_busy) do_done(); else do_read(IW'($urandom), "R2 random read");
      endcase
    end
    for (int i = 0; i < NB; i++) do_read(IW'(i), "R10 sweep");

    // R1/R11: mid-run reset
    do_cmd(2'b00, 3'd0, 1'b1);
    do_reset();
    chk("R11 cfg restored", 32'(cfg_q), 32'(CFG_DEF));
    for (int i = 0; i < NB; i++) do_read(IW'(i), "R1 relocked after reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule